// File: doc/BRIEF.md
# Bi-phase Infrared Frame Receiver

This block takes the demodulated output of an infrared receiver, which idles high, and recovers one 14-bit Manchester-coded remote-control frame from it. Time is measured in ticks of a 32768 Hz enable, so that one bit cell lasts about 58 ticks (1.78 ms). The line is first passed through a two-flop synchronizer and an edge detector. A falling edge on an idle line starts a frame. After every accepted edge the receiver waits 44 ticks, which is three quarters of a bit, and takes the line level there as the next bit. Once the bit is stored, the receiver waits for the next edge in either direction. If that edge does not arrive within 29 ticks, the frame is dropped.

The receiver takes 14 samples. The first 13 are shifted in MSB first. The fourteenth sample only marks the end of the frame. The low 12 bits of the shift register hold the control bit, the five address bits and the six command bits, and they are presented with a one-cycle valid strobe. A match flag shows whether the 6-bit command of the last good frame equals a configured code. A dropped frame raises a one-cycle error strobe.

The controller is a three-state machine:
- **S_IDLE**: waits for a falling edge.
- **S_DELAY**: counts the delay to the sample point.
- **S_WAIT**: watches for the next edge within the timeout.

It has five transitions:
- **T_ARM** (S_IDLE→S_DELAY): on a falling edge.
- **T_SAMPLE** (S_DELAY→S_WAIT): at the sample point while samples remain.
- **T_DONE** (S_DELAY→S_IDLE): at the last sample point.
- **T_EDGE** (S_WAIT→S_DELAY): on any edge.
- **T_ABORT** (S_WAIT→S_IDLE): when the timeout expires.

Top module: `ir_biphase_rx`

## Requirements
- R1: After reset, `code_o` is 0 and `code_valid`, `frame_err` and `cmd_match` are all low.
- R2: While idle, only a falling edge on `ir_in` starts a frame. A rising edge while idle causes neither a valid nor an error strobe.
- R3: A bit is sampled 44 ticks after each accepted edge. The valid strobe of a frame appears 44 ticks (plus the synchronizer delay) after the mid-cell edge of its last bit.
- R4: After each sample, edges of either polarity are accepted, so a frame whose cell boundaries shift by up to 10 ticks still decodes.
- R5: If no edge arrives within 29 ticks of a sample, the frame is dropped, `frame_err` pulses, and no valid strobe is produced.
- R6: Bits enter MSB first. For a frame whose cells carry 1, 1, c11 … c0 (each cell high then low for a 1, low then high for a 0), `code_o` equals c11..c0.
- R7: The fourteenth sample completes the frame. `code_valid` is high for exactly one clock cycle per good frame.
- R8: At completion, `cmd_match` is set when `code_o[5:0]` equals 32 and cleared otherwise. It keeps its value until the next completion, including across dropped frames.
- R9: After a completion or an abort, the receiver is idle and decodes the next well-formed frame.
- R10: `frame_err` is high for exactly one cycle per dropped frame, and it is never high in the same cycle as `code_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at 32768 Hz |
| ir_in | input | 1 | Demodulated receiver line, idle high, asynchronous |
| code_o | output | 12 | Control, address and command bits of the last good frame |
| code_valid | output | 1 | One-cycle strobe for a new `code_o` |
| cmd_match | output | 1 | Command field of the last good frame equals the configured code |
| frame_err | output | 1 | One-cycle strobe for a frame dropped on timeout |

## Verification
The path hardest to reach from the ports is an abort in the middle of a frame. It needs a frame that starts correctly and then leaves the line quiet for more than the timeout, at a point where a correct receiver has already shifted bits in. The bench reaches it with a frame generator that can lengthen any chosen half cell. A lengthening of 40 ticks forces T_ABORT, and a lengthening of 10 ticks must still decode. After the abort, the bench sends a clean frame to show the rearm, and checks that the match flag survives the abort.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DELAY = 2'd1,
        S_WAIT  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= IDLE_LVL;
            sync_q <= IDLE_LVL;
            hist_q <= IDLE_LVL;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~hist_q;
    assign fall_o  = ~sync_q & hist_q;

endmodule

// File: rtl/ir_tick_timer.sv
module ir_tick_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/ir_frame_shift.sv
module ir_frame_shift #(
    parameter int CODE_W  = 12,
    parameter int NSAMP   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              sample_i,
    input  logic              bit_i,
    output logic [CODE_W-1:0] data_o,
    output logic              last_o
);

    localparam int SC_W = $clog2(NSAMP + 1);
    localparam logic [SC_W-1:0] SC_INIT = SC_W'(NSAMP);
    localparam logic [SC_W-1:0] SC_ONE  = SC_W'(1);

    logic [CODE_W-1:0] sh_q;
    logic [SC_W-1:0]   left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= SC_INIT;
        end else if (load_i) begin
            sh_q   <= '0;
            left_q <= SC_INIT;
        end else if (sample_i) begin
            if (left_q == SC_ONE) begin
                left_q <= SC_INIT;
            end else begin
                left_q <= left_q - 1'b1;
                sh_q   <= {sh_q[CODE_W-2:0], bit_i};
            end
        end
    end

    assign data_o = sh_q;
    assign last_o = (left_q == SC_ONE);

    // R7: remaining-sample counter stays within its legal range
    p_left_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q >= SC_ONE) && (left_q <= SC_INIT));

    // R6: a non-final sample moves the previous LSB up one place
    p_shift_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !load_i && !last_o) |=> (sh_q[1] == $past(sh_q[0])));

endmodule

// File: rtl/ir_rx_fsm.sv
module ir_rx_fsm
    import ir_rx_pkg::*;
#(
    parameter int CODE_W        = 12,
    parameter int CMD_W         = 6,
    parameter int MATCH_CMD     = 32,
    parameter int SAMPLE_TICKS  = 44,
    parameter int TIMEOUT_TICKS = 29,
    parameter int CNT_W         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic [CNT_W-1:0]  tmr_cnt_i,
    input  logic              last_i,
    input  logic [CODE_W-1:0] shift_data_i,
    output logic              tmr_clear_o,
    output logic              shift_load_o,
    output logic              shift_sample_o,
    output logic [CODE_W-1:0] code_o,
    output logic              code_valid_o,
    output logic              cmd_match_o,
    output logic              frame_err_o
);

    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(SAMPLE_TICKS - 1);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_TICKS - 1);
    localparam logic [CMD_W-1:0] CMD_REF  = CMD_W'(MATCH_CMD);

    rx_state_t state_q, state_d;
    logic      delay_hit;
    logic      timeout_hit;
    logic      any_edge;
    logic      done_now;
    logic      abort_now;

    assign delay_hit   = tick_i && (tmr_cnt_i == DLY_LAST);
    assign timeout_hit = tick_i && (tmr_cnt_i == TMO_LAST);
    assign any_edge    = fall_i | rise_i;

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        done_now  = 1'b0;
        abort_now = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (fall_i) state_d = S_DELAY;            // T_ARM
            end
            S_DELAY: begin
                if (delay_hit) begin
                    if (last_i) begin
                        state_d  = S_IDLE;                // T_DONE
                        done_now = 1'b1;
                    end else begin
                        state_d  = S_WAIT;                // T_SAMPLE
                    end
                end
            end
            S_WAIT: begin
                if (any_edge) begin
                    state_d = S_DELAY;                    // T_EDGE
                end else if (timeout_hit) begin
                    state_d   = S_IDLE;                   // T_ABORT
                    abort_now = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign tmr_clear_o    = (state_q == S_IDLE) || (state_d != state_q);
    assign shift_load_o   = (state_q == S_IDLE) && fall_i;
    assign shift_sample_o = (state_q == S_DELAY) && delay_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o       <= '0;
            code_valid_o <= 1'b0;
            cmd_match_o  <= 1'b0;
            frame_err_o  <= 1'b0;
        end else begin
            code_valid_o <= done_now;
            frame_err_o  <= abort_now;
            if (done_now) begin
                code_o      <= shift_data_i;
                cmd_match_o <= (shift_data_i[CMD_W-1:0] == CMD_REF);
            end
        end
    end

    // R2: an idle receiver stays idle without a falling edge
    p_idle_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !fall_i) |=> (state_q == S_IDLE));

    // R3: the delay count never passes the sample point
    p_delay_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DELAY) |-> (tmr_cnt_i < CNT_W'(SAMPLE_TICKS)));

    // R5: the edge wait never passes the timeout
    p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |-> (tmr_cnt_i < CNT_W'(TIMEOUT_TICKS)));

    // R7: valid strobe lasts one cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |=> !code_valid_o);

    // R10: error strobe lasts one cycle and never coincides with valid
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);
    p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err_o && code_valid_o));

    // R8: the match flag only moves together with a valid strobe
    p_match_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_match_o) |-> code_valid_o);

    // R9: after an abort the receiver is idle
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> (state_q == S_IDLE));

endmodule

// File: rtl/ir_biphase_rx.sv
module ir_biphase_rx #(
    parameter int CODE_W        = 12,
    parameter int CMD_W         = 6,
    parameter int NSAMP         = 14,
    parameter int MATCH_CMD     = 32,
    parameter int SAMPLE_TICKS  = 44,
    parameter int TIMEOUT_TICKS = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ir_in,
    output logic [CODE_W-1:0] code_o,
    output logic              code_valid,
    output logic              cmd_match,
    output logic              frame_err
);

    localparam int MAX_TICKS = (SAMPLE_TICKS > TIMEOUT_TICKS) ? SAMPLE_TICKS : TIMEOUT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic              lvl;
    logic              rise;
    logic              fall;
    logic              tmr_clear;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              sh_load;
    logic              sh_sample;
    logic              sh_last;
    logic [CODE_W-1:0] sh_data;

    ir_line_sync #(.IDLE_LVL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (ir_in),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    ir_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .tick_i  (tick_en),
        .count_o (tmr_cnt)
    );

    ir_frame_shift #(.CODE_W(CODE_W), .NSAMP(NSAMP)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (sh_load),
        .sample_i (sh_sample),
        .bit_i    (lvl),
        .data_o   (sh_data),
        .last_o   (sh_last)
    );

    ir_rx_fsm #(
        .CODE_W        (CODE_W),
        .CMD_W         (CMD_W),
        .MATCH_CMD     (MATCH_CMD),
        .SAMPLE_TICKS  (SAMPLE_TICKS),
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_en),
        .fall_i         (fall),
        .rise_i         (rise),
        .tmr_cnt_i      (tmr_cnt),
        .last_i         (sh_last),
        .shift_data_i   (sh_data),
        .tmr_clear_o    (tmr_clear),
        .shift_load_o   (sh_load),
        .shift_sample_o (sh_sample),
        .code_o         (code_o),
        .code_valid_o   (code_valid),
        .cmd_match_o    (cmd_match),
        .frame_err_o    (frame_err)
    );

endmodule

// File: tb/ir_biphase_rx_bench.sv
module ir_biphase_rx_bench;

    localparam int TDIV  = 4;
    localparam int HALF  = 29;
    localparam int LIMIT = 150000;
    localparam int NV    = 8;
    localparam logic [11:0] VEC [NV] = '{
        12'h020, 12'h000, 12'hFFF, 12'h7E0,
        12'h021, 12'hAAA, 12'h555, 12'h860
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en;
    logic        ir_in = 1'b1;
    logic [11:0] code_o;
    logic        code_valid;
    logic        cmd_match;
    logic        frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tcnt = 0;
    int n_valid = 0;
    int n_err = 0;
    int n_wide = 0;
    int t_valid = 0;
    int t_mid = 0;
    logic [11:0] got_code = '0;
    logic        got_match = 1'b0;
    logic        prev_v = 1'b0;
    logic        prev_e = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign tick_en = (tcnt == TDIV - 1);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    end

    ir_biphase_rx u_ir_biphase_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ir_in      (ir_in),
        .code_o     (code_o),
        .code_valid (code_valid),
        .cmd_match  (cmd_match),
        .frame_err  (frame_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (code_valid) begin
                n_valid++;
                got_code  = code_o;
                got_match = cmd_match;
                t_valid   = cyc;
            end
            if (frame_err) n_err++;
            if ((code_valid && prev_v) || (frame_err && prev_e) || (code_valid && frame_err))
                n_wide++;
            prev_v = code_valid;
            prev_e = frame_err;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    task automatic send_frame(input logic [11:0] code, input int s_idx, input int s_amt);
        logic [13:0] bits;
        bits = {2'b11, code};
        for (int i = 13; i >= 0; i--) begin
            ir_in = bits[i];
            wait_ticks(HALF + ((i == s_idx) ? s_amt : 0));
            ir_in = ~bits[i];
            if (i == 0) t_mid = cyc;
            wait_ticks(HALF);
        end
        ir_in = 1'b1;
        wait_ticks(80);
    endtask

    initial begin
        int v0, e0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(code_o == 12'h000, "R1 code", code_o, 0);
        chk(!code_valid && !frame_err && !cmd_match, "R1 strobes",
            {code_valid, frame_err, cmd_match}, 0);
        rst_n = 1'b1;
        wait_ticks(10);

        // R2: a falling edge arms; lone low line then times out
        v0 = n_valid; e0 = n_err;
        ir_in = 1'b0;
        wait_ticks(120);
        chk(n_err == e0 + 1, "R2 fall arms (R5 abort)", n_err - e0, 1);
        // R2: rising edge in idle is ignored
        v0 = n_valid; e0 = n_err;
        ir_in = 1'b1;
        wait_ticks(150);
        chk(n_err == e0 && n_valid == v0, "R2 rise ignored",
            (n_err - e0) + (n_valid - v0), 0);

        // Table walk: R6, R7, R8, R3
        for (int k = 0; k < NV; k++) begin
            v0 = n_valid; e0 = n_err;
            send_frame(VEC[k], -1, 0);
            chk(n_valid == v0 + 1 && n_err == e0, "R7 one valid per frame", n_valid - v0, 1);
            chk(got_code == VEC[k], "R6 code", got_code, VEC[k]);
            chk(got_match == (VEC[k][5:0] == 6'd32), "R8 match", got_match,
                (VEC[k][5:0] == 6'd32));
            chk((t_valid - t_mid) >= 44 * TDIV && (t_valid - t_mid) <= 45 * TDIV + 8,
                "R3 sample latency", t_valid - t_mid, 44 * TDIV);
        end

        // R4: shifted cell boundary still decodes
        v0 = n_valid;
        send_frame(12'h3C5, 7, 10);
        chk(n_valid == v0 + 1 && got_code == 12'h3C5, "R4 shifted edge", got_code, 12'h3C5);

        // R8 hold: set match, then abort keeps it
        send_frame(12'h0A0, -1, 0);
        chk(cmd_match == 1'b1, "R8 match set", cmd_match, 1);

        // R5/R10: long half after a sample aborts mid-frame
        v0 = n_valid; e0 = n_err;
        send_frame(12'h123, 6, 40);
        chk(n_err >= e0 + 1, "R5 timeout abort", n_err - e0, 1);
        chk(n_valid == v0, "R10 no valid on abort", n_valid - v0, 0);
        chk(cmd_match == 1'b1, "R8 match held over abort", cmd_match, 1);

        // R9: rearm after abort
        v0 = n_valid; e0 = n_err;
        wait_ticks(100);
        send_frame(12'h9B4, -1, 0);
        chk(n_valid == v0 + 1 && got_code == 12'h9B4, "R9 rearm", got_code, 12'h9B4);
        chk(cmd_match == 1'b0, "R8 match cleared", cmd_match, 0);

        // R7/R10: strobe widths
        chk(n_wide == 0, "R10 strobe width", n_wide, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > LIMIT);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule